// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block gathers event pulses from a set of on-chip peripheral sources and records each in a pending register. It presents a single interrupt request to a processor. A request can come only from a source that is pending, enabled in the enable-mask register and not blocked by an in-service source. Among those, the source with the highest fixed priority wins, and source index `NUM_SRC-1` is the highest. The request carries a programmable priority level from 1 to 7.

When the processor runs an acknowledge at that level, the block returns a vector on the next cycle. The vector is a programmable 3-bit base placed above the winner's 5-bit index. In the same cycle the block clears the winner's pending bit and sets its in-service bit. An in-service bit holds back every source of equal or lower priority until software clears it. A source of strictly higher priority can therefore interrupt a lower handler at the same level, which gives nesting.

Software reaches the pending, mask, in-service and configuration registers through a simple port. Writes take effect at the clock edge and reads are combinational. With every mask bit cleared, software can poll the pending register and no request is raised.

Top module: `nest_irq_ctrl`

## Requirements
- R1: `irq_req` is high exactly when some source is pending and enabled and has an index above the highest set in-service index (or no in-service bit is set), and `irq_lvl` always shows the configured level.
- R2: An acknowledge is accepted when `iack` is high and `iack_lvl` equals the configured level. In the cycle after an accepted acknowledge, `vec_vld` is high and `vec_out` = {base[2:0], winner index[4:0]}, where the winner is the highest eligible index at the acknowledge edge. `vec_vld` is low after any cycle without an accepted acknowledge.
- R3: An accepted acknowledge clears the winner's pending bit. The remaining requests are prioritized again, and the request stays or returns high if any source is still eligible.
- R4: An accepted acknowledge with a winner sets that winner's in-service bit.
- R5: While in-service bit k is set, no source with index ≤ k raises a request, but a pending enabled source with index > k does.
- R6: A source event sets its pending bit even while that source is masked or blocked. With the mask register all zero, `irq_req` stays low.
- R7: Pending and in-service bits clear only when software writes a one to them, and a written zero leaves a bit unchanged. The block never clears an in-service bit by itself. A hardware set in the same cycle as a software clear leaves the bit set.
- R8: An acknowledge whose level does not match is ignored: no `vec_vld`, and pending and in-service are unchanged.
- R9: An accepted acknowledge with no eligible source returns the vector 8'hFF and changes no pending or in-service bit.
- R10: Synchronous reset clears pending, mask and in-service, drives `irq_req` low, and sets the level to 1 and the base to 0. A configuration write with level 0 keeps the old level and still updates the base.
- R11: Register addresses: 0 = pending (write-one-to-clear), 1 = enable mask (a one enables), 2 = in-service (write-one-to-clear), 3 = configuration with the level in bits [2:0] and the base in bits [6:4]. `reg_rdata` shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | NUM_SRC | Per-source event, sets pending when high at an edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_lvl | output | 3 | Priority level of the request |
| iack | input | 1 | Acknowledge strobe from the processor |
| iack_lvl | input | 3 | Level being acknowledged |
| vec_vld | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| vec_out | output | 8 | Vector number |

## Verification
The bench goes after the cases where the order of operations in a single cycle matters. One is an event that arrives in the same cycle as a software clear of the same pending bit; a design that lets the clear win loses that event. Another is nesting: a lower pending source must stay silent behind an in-service bit while a higher one gets through. A design that compares with ≥ instead of > would re-enter the running handler, and one that ignores in-service would never nest. The bench also checks an acknowledge at the wrong level, which must not consume a source, an acknowledge with nothing eligible, which must return all ones, a level write of zero, and masked events that must still latch. Long random runs compare every output and every register against a cycle model.

// File: rtl/nic_pkg.sv
// Package: shared register addresses and reset constants for the
// nested interrupt controller. Assumes a 2-bit register address space.
package nic_pkg;
    localparam int LVL_W  = 3;
    localparam int BASE_W = 3;

    typedef enum logic [1:0] {
        RA_PEND = 2'd0,
        RA_MASK = 2'd1,
        RA_INSV = 2'd2,
        RA_CFG  = 2'd3
    } reg_addr_e;

    localparam logic [LVL_W-1:0]  LVL_RST  = 3'd1;
    localparam logic [BASE_W-1:0] BASE_RST = 3'd0;
endpackage

// File: rtl/nic_prio_pick.sv
// Fixed-priority picker: reports whether any bit of req_vec is set and the
// index of the highest set bit. Assumes IW = $clog2(WIDTH), supplied by the parent.
module nic_prio_pick #(
    parameter int WIDTH = 32,
    parameter int IW    = 5
) (
    input  logic [WIDTH-1:0] req_vec,
    output logic             hit,
    output logic [IW-1:0]    top_idx
);

    // Scan upward so the last set bit found is the highest one.
    always_comb begin
        hit     = 1'b0;
        top_idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (req_vec[i]) begin
                hit     = 1'b1;
                top_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/nic_src_bank.sv
// Per-source state: pending, enable mask and in-service bits.
// Pending: set by events, cleared by the acknowledge hit or a software write of one.
// In-service: set by the acknowledge hit, cleared only by a software write of one.
// A hardware set wins over a software clear in the same cycle.
// Assumes ack_hit is one-hot or zero.
module nic_src_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [NUM_SRC-1:0] sw_pend_clr,
    input  logic               mask_wr,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic [NUM_SRC-1:0] sw_insv_clr,
    input  logic [NUM_SRC-1:0] ack_hit,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] insv_q
);

    // Enable mask register, written as a whole word.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Pending bit: a set from an event beats either kind of clear.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= src_evt[i] | (pend_q[i] & ~ack_hit[i] & ~sw_pend_clr[i]);
        end

        // In-service bit: a set from the acknowledge beats a software clear.
        always_ff @(posedge clk) begin
            if (!rst_n) insv_q[i] <= 1'b0;
            else        insv_q[i] <= ack_hit[i] | (insv_q[i] & ~sw_insv_clr[i]);
        end

        AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[i] |=> pend_q[i]); // R6
        AST_INSV_SW_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(insv_q[i]) |-> $past(sw_insv_clr[i])); // R7
        AST_ACK_MARKS_INSV: assert property (@(posedge clk) disable iff (!rst_n)
            ack_hit[i] |=> insv_q[i]); // R4
    end

endmodule

// File: rtl/nic_ack_unit.sv
// Acknowledge handshake: accepts iack only at the configured level, marks the
// winning source for clearing, and registers the vector (or all ones if
// nothing is eligible) with a one-cycle valid strobe.
// Assumes win_idx is meaningful only while win_any is high.
module nic_ack_unit #(
    parameter int NUM_SRC = 32,
    parameter int IW      = 5,
    parameter int LVL_W   = 3,
    parameter int BASE_W  = 3,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iack,
    input  logic [LVL_W-1:0]   iack_lvl,
    input  logic [LVL_W-1:0]   cur_lvl,
    input  logic [BASE_W-1:0]  vbase,
    input  logic               win_any,
    input  logic [IW-1:0]      win_idx,
    output logic               accept,
    output logic [NUM_SRC-1:0] ack_hit,
    output logic               vec_vld,
    output logic [VEC_W-1:0]   vec_out
);

    // Acceptance only when the processor acknowledges our level.
    assign accept = iack && (iack_lvl == cur_lvl);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
        assign ack_hit[i] = accept && win_any && (win_idx == IW'(i));
    end

    // Valid strobe, one cycle per accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) vec_vld <= 1'b0;
        else        vec_vld <= accept;
    end

    // Vector capture: base over index, or the spurious code.
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_out <= '1;
        else if (accept) vec_out <= win_any ? {vbase, win_idx} : '1;
    end

    AST_ACK_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> vec_vld); // R2
    AST_NO_ACK_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !vec_vld); // R8
    AST_SPURIOUS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !win_any) |=> (vec_out == '1)); // R9
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit)); // R4

endmodule

// File: rtl/nest_irq_ctrl.sv
// Top of the nested prioritized interrupt controller. Holds the level/base
// configuration, decodes register writes into per-source clear masks,
// computes the in-service block threshold and eligibility, and picks the
// highest eligible source. Assumes NUM_SRC >= 7 so the configuration fits.
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int VEC_W   = BASE_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_req,
    output logic [LVL_W-1:0]   irq_lvl,
    input  logic               iack,
    input  logic [LVL_W-1:0]   iack_lvl,
    output logic               vec_vld,
    output logic [VEC_W-1:0]   vec_out
);

    localparam int CFG_BASE_LSB = 4;

    logic [LVL_W-1:0]   lvl_q;
    logic [BASE_W-1:0]  base_q;
    logic [NUM_SRC-1:0] pend_q, mask_q, insv_q;
    logic [NUM_SRC-1:0] sw_pend_clr, sw_insv_clr, ack_hit;
    logic [NUM_SRC-1:0] unblk, elig;
    logic               mask_wr, cfg_wr;
    logic               insv_any, win_any, accept;
    logic [IDX_W-1:0]   insv_top, win_idx;
    reg_addr_e          addr_e;

    assign addr_e      = reg_addr_e'(reg_addr);
    assign mask_wr     = reg_wr && (addr_e == RA_MASK);
    assign cfg_wr      = reg_wr && (addr_e == RA_CFG);
    assign sw_pend_clr = (reg_wr && addr_e == RA_PEND) ? reg_wdata : '0;
    assign sw_insv_clr = (reg_wr && addr_e == RA_INSV) ? reg_wdata : '0;

    // Configuration: base always written, level only when non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= LVL_RST;
            base_q <= BASE_RST;
        end else if (cfg_wr) begin
            base_q <= reg_wdata[CFG_BASE_LSB +: BASE_W];
            if (reg_wdata[LVL_W-1:0] != '0) lvl_q <= reg_wdata[LVL_W-1:0];
        end
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (addr_e)
            RA_PEND: reg_rdata = pend_q;
            RA_MASK: reg_rdata = mask_q;
            RA_INSV: reg_rdata = insv_q;
            RA_CFG: begin
                reg_rdata[LVL_W-1:0]                 = lvl_q;
                reg_rdata[CFG_BASE_LSB +: BASE_W]    = base_q;
            end
        endcase
    end

    nic_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt    (src_evt),
        .sw_pend_clr(sw_pend_clr),
        .mask_wr    (mask_wr),
        .mask_wdata (reg_wdata),
        .sw_insv_clr(sw_insv_clr),
        .ack_hit    (ack_hit),
        .pend_q     (pend_q),
        .mask_q     (mask_q),
        .insv_q     (insv_q)
    );

    // Highest in-service source sets the block threshold.
    nic_prio_pick #(.WIDTH(NUM_SRC), .IW(IDX_W)) u_insv_pick (
        .req_vec(insv_q),
        .hit    (insv_any),
        .top_idx(insv_top)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign unblk[i] = !insv_any || (i > int'(insv_top));
        assign elig[i]  = pend_q[i] && mask_q[i] && unblk[i];
    end

    // Highest eligible source wins the request.
    nic_prio_pick #(.WIDTH(NUM_SRC), .IW(IDX_W)) u_win_pick (
        .req_vec(elig),
        .hit    (win_any),
        .top_idx(win_idx)
    );

    nic_ack_unit #(
        .NUM_SRC(NUM_SRC),
        .IW     (IDX_W),
        .LVL_W  (LVL_W),
        .BASE_W (BASE_W),
        .VEC_W  (VEC_W)
    ) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .iack    (iack),
        .iack_lvl(iack_lvl),
        .cur_lvl (lvl_q),
        .vbase   (base_q),
        .win_any (win_any),
        .win_idx (win_idx),
        .accept  (accept),
        .ack_hit (ack_hit),
        .vec_vld (vec_vld),
        .vec_out (vec_out)
    );

    assign irq_req = win_any;
    assign irq_lvl = lvl_q;

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_req); // R6
    AST_WIN_ABOVE_INSV: assert property (@(posedge clk) disable iff (!rst_n)
        (win_any && insv_any) |-> (win_idx > insv_top)); // R5
    AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        win_any |-> pend_q[win_idx]); // R1
    AST_ACK_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_any && !src_evt[win_idx]) |=> !pend_q[$past(win_idx)]); // R3
    AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lvl != '0); // R10

endmodule

// File: tb/tb_nest_irq_ctrl.sv
`timescale 1ns/1ps
module tb_nest_irq_ctrl;
    localparam int N = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n;
    logic [N-1:0] src_evt;
    logic         reg_wr;
    logic [1:0]   reg_addr;
    logic [N-1:0] reg_wdata;
    logic [N-1:0] reg_rdata;
    logic         irq_req;
    logic [2:0]   irq_lvl;
    logic         iack;
    logic [2:0]   iack_lvl;
    logic         vec_vld;
    logic [7:0]   vec_out;

    nest_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .iack(iack), .iack_lvl(iack_lvl),
        .vec_vld(vec_vld), .vec_out(vec_out)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [N-1:0] m_pend, m_mask, m_insv;
    logic [2:0]   m_lvl, m_base;
    logic         m_vld;
    logic [7:0]   m_vec;

    function automatic int m_win();
        int top_insv = -1;
        int w = -1;
        for (int i = 0; i < N; i++) if (m_insv[i]) top_insv = i;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && m_mask[i] && i > top_insv) w = i;
        return w;
    endfunction

    function automatic logic [N-1:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_pend;
            2'd1: return m_mask;
            2'd2: return m_insv;
            default: return {25'd0, m_base, 1'b0, m_lvl};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_step();
        int w = m_win();
        logic acc = iack && (iack_lvl == m_lvl);
        logic [N-1:0] p = m_pend;
        logic [N-1:0] s = m_insv;
        if (acc && w >= 0) p[w] = 1'b0;
        if (reg_wr && reg_addr == 2'd0) p = p & ~reg_wdata;
        p = p | src_evt;
        if (reg_wr && reg_addr == 2'd2) s = s & ~reg_wdata;
        if (acc && w >= 0) s[w] = 1'b1;
        m_vld = acc;
        if (acc) m_vec = (w < 0) ? 8'hFF : {m_base, 5'(w)};
        if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata;
        if (reg_wr && reg_addr == 2'd3) begin
            m_base = reg_wdata[6:4];
            if (reg_wdata[2:0] != 3'd0) m_lvl = reg_wdata[2:0];
        end
        m_pend = p;
        m_insv = s;
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic cycle(input logic [N-1:0] evt, input logic wr, input logic [1:0] a,
                         input logic [N-1:0] wd, input logic ak, input logic [2:0] al);
        @(negedge clk);
        src_evt = evt; reg_wr = wr; reg_addr = a; reg_wdata = wd; iack = ak; iack_lvl = al;
        #1;
        chk("R1 request", 32'(irq_req), 32'(m_win() >= 0));
        chk("R1 level", 32'(irq_lvl), 32'(m_lvl));
        chk("R11 read data", reg_rdata, m_read(a));
        chk("R2 valid", 32'(vec_vld), 32'(m_vld));
        if (m_vld) chk("R2 vector", 32'(vec_out), 32'(m_vec));
        m_step();
    endtask

    task automatic idle(input logic [1:0] a);
        cycle('0, 1'b0, a, '0, 1'b0, 3'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; src_evt = '0; reg_wr = 1'b0; reg_addr = 2'd0;
        reg_wdata = '0; iack = 1'b0; iack_lvl = 3'd0;
        m_pend = '0; m_mask = '0; m_insv = '0; m_lvl = 3'd1; m_base = 3'd0;
        m_vld = 1'b0; m_vec = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state
        idle(2'd0); chk("R10 pending after reset", reg_rdata, 32'h0);
        chk("R10 request after reset", 32'(irq_req), 32'h0);
        idle(2'd2); chk("R10 in-service after reset", reg_rdata, 32'h0);
        idle(2'd3); chk("R10 config after reset", reg_rdata, 32'h1);

        // R6: masked events still latch, no request
        cycle(32'h88, 1'b0, 2'd0, '0, 1'b0, 3'd0);
        idle(2'd0); chk("R6 masked latch", reg_rdata, 32'h88);
        chk("R6 no request when masked", 32'(irq_req), 32'h0);

        // R10/R11: config, level 0 ignored
        cycle('0, 1'b1, 2'd3, 32'h25, 1'b0, 3'd0);
        cycle('0, 1'b1, 2'd3, 32'h20, 1'b0, 3'd0);
        idle(2'd3); chk("R10 level zero ignored", 32'(irq_lvl), 32'd5);
        chk("R11 config read", reg_rdata, 32'h25);

        // R1: enable all
        cycle('0, 1'b1, 2'd1, '1, 1'b0, 3'd0);
        idle(2'd0); chk("R1 request raised", 32'(irq_req), 32'h1);

        // R8: wrong level ignored
        cycle('0, 1'b0, 2'd0, '0, 1'b1, 3'd3);
        idle(2'd0); chk("R8 no valid", 32'(vec_vld), 32'h0);
        chk("R8 pending unchanged", reg_rdata, 32'h88);

        // R2/R3/R4/R5: accepted acknowledge picks source 7
        cycle('0, 1'b0, 2'd0, '0, 1'b1, 3'd5);
        idle(2'd0); chk("R2 vector for source 7", 32'(vec_out), 32'h47);
        chk("R3 pending cleared", reg_rdata, 32'h08);
        chk("R5 lower source blocked", 32'(irq_req), 32'h0);
        idle(2'd2); chk("R4 in-service set", reg_rdata, 32'h80);

        // R5: higher source nests
        cycle(32'h200, 1'b0, 2'd0, '0, 1'b0, 3'd0);
        idle(2'd0); chk("R5 higher source nests", 32'(irq_req), 32'h1);
        cycle('0, 1'b0, 2'd0, '0, 1'b1, 3'd5);
        idle(2'd2); chk("R5 nested vector", 32'(vec_out), 32'h49);
        chk("R4 nested in-service", reg_rdata, 32'h280);

        // R7: set wins over clear, zero write no effect
        cycle(32'h08, 1'b1, 2'd0, 32'h08, 1'b0, 3'd0);
        idle(2'd0); chk("R7 set beats clear", reg_rdata, 32'h08);
        cycle('0, 1'b1, 2'd2, 32'h0, 1'b0, 3'd0);
        repeat (5) idle(2'd2);
        chk("R7 in-service held", reg_rdata, 32'h280);
        cycle('0, 1'b1, 2'd2, 32'h200, 1'b0, 3'd0);
        idle(2'd2); chk("R7 one-bit clear", reg_rdata, 32'h80);

        // R9: spurious acknowledge
        cycle('0, 1'b1, 2'd1, 32'h0, 1'b0, 3'd0);
        cycle('0, 1'b0, 2'd0, '0, 1'b1, 3'd5);
        idle(2'd2); chk("R9 valid on spurious", 32'(vec_vld), 32'h1);
        chk("R9 spurious vector", 32'(vec_out), 32'hFF);
        chk("R9 in-service unchanged", reg_rdata, 32'h80);
        cycle('0, 1'b1, 2'd2, '1, 1'b0, 3'd0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [N-1:0] evt = $urandom & $urandom & $urandom;
            logic wr = ($urandom % 4) == 0;
            logic [1:0] a = 2'($urandom);
            logic [N-1:0] wd = (a == 2'd1 || a == 2'd3) ? N'($urandom) : N'($urandom & $urandom);
            logic ak = ($urandom % 4) == 0;
            logic [2:0] al = (($urandom % 10) < 7) ? m_lvl : 3'($urandom);
            cycle(evt, wr, a, wd, ak, al);
        end
        idle(2'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule